// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a two-wire serial memory slave. It watches a clock line and a data line sampled in the system clock domain, finds START and STOP conditions, and answers to one fixed 7-bit device address. A write transaction first carries one byte that sets the internal address pointer, then data bytes that are handed to a page buffer through a write strobe. A STOP after at least one data byte sends a commit pulse, which starts the timed non-volatile write.

Read transactions send bytes from the memory's read port, most significant bit first, starting at the address pointer. A random read is made of a write-direction address phase, a repeated START and a read-direction device byte. A current-address read simply begins where the pointer was left. While the memory reports busy, the engine stays deaf to the bus and does not acknowledge its address. A master can therefore poll for the end of the write by repeating START plus device byte until it gets an acknowledge.

Only the pull-low enable for the data pad is produced. The pad driver, clock stretching, 10-bit addressing and general call are left to the surroundings.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the data-pad pull-low output is 0, and no write strobe or commit pulse is issued until a transaction asks for one.
- R2: START is the data line falling while the clock line is high, and STOP is the data line rising while the clock line is high, both after a two-flop synchronizer. A device byte whose upper seven bits differ from DEV_ADDR is not acknowledged, and every later byte is ignored until the next START.
- R3: A device byte with matching upper seven bits is acknowledged by pulling data low during the ninth clock (bit 0 of that byte: 0 = write, 1 = read). In write direction the next byte is loaded into the address pointer and acknowledged.
- R4: Each data byte after the pointer byte is acknowledged and causes exactly one one-cycle write strobe that carries the current pointer as address and the byte as data. The pointer then advances.
- R5: During writes only the low PAGE_BITS bits of the pointer advance, so the address wraps inside its page. When more bytes than a page holds are sent, the later bytes overwrite the earlier ones.
- R6: A one-cycle commit pulse is issued on STOP only when at least one data byte was written since the last START. A repeated START discards the pending bytes, and so does a STOP after only a pointer byte.
- R7: In read direction bytes are sent most significant bit first from the read port at the pointer. The pointer steps by one through the whole address space and wraps from the top address to 0.
- R8: The pointer keeps its value between transactions. A current-address read starts at it, and a random read starts at the address given in the write-direction phase before the repeated START.
- R9: A read continues while the master acknowledges. After the master withholds the acknowledge, the data pad is released and further clocks are ignored until the next START.
- R10: While the memory busy input is high, START is ignored, no device byte is acknowledged and no strobe is issued. Once busy is low, a START plus matching device byte is acknowledged again.
- R11: With write protect high, a write-direction device byte is not acknowledged and nothing is written. Read-direction device bytes are still acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_low | output | 1 | 1 = pull the data pad low |
| wr_protect | input | 1 | 1 = refuse write-direction device bytes |
| mem_busy | input | 1 | Non-volatile write in progress |
| mem_raddr | output | AW | Read address (the address pointer) |
| mem_rdata | input | 8 | Read data, valid one clock after mem_raddr |
| mem_we | output | 1 | One-cycle write strobe to the page buffer |
| mem_waddr | output | AW | Address for the write strobe |
| mem_wdata | output | 8 | Data for the write strobe |
| mem_commit | output | 1 | One-cycle pulse that starts the timed write |

## Verification
The sharpest collision is between the end of a write and a new transaction. The commit pulse raises busy in the same stretch of cycles in which the master's next START and device byte arrive. The bench provokes this by polling at once after the STOP of a byte write. It expects no acknowledge while busy holds, an acknowledge once it has dropped, and the committed byte readable afterwards. A second case puts a repeated START right after a data byte, and the bench expects that no commit follows.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_MADDR,
    ST_MADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } proto_st_t;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_q, sda_q;
  logic scl_now, scl_prev, sda_now, sda_prev;

  // synchronizer chain plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[DEPTH-2:0], scl_i};
      sda_q <= {sda_q[DEPTH-2:0], sda_i};
    end
  end

  assign scl_now  = scl_q[SYNC_STAGES-1];
  assign scl_prev = scl_q[SYNC_STAGES];
  assign sda_now  = sda_q[SYNC_STAGES-1];
  assign sda_prev = sda_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      sda_lvl   <= 1'b1;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_rise  <= scl_now & ~scl_prev;
      scl_fall  <= ~scl_now & scl_prev;
      sda_lvl   <= sda_now;
      start_det <= scl_now & scl_prev & sda_prev & ~sda_now;
      stop_det  <= scl_now & scl_prev & ~sda_prev & sda_now;
    end
  end
endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
  parameter int AW        = 8,
  parameter int PAGE_BITS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_page,
  input  logic          inc_full,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] full_next, page_next;

  assign full_next = ptr + AW'(1);

  generate
    if (PAGE_BITS >= AW) begin : g_flat
      assign page_next = full_next;
    end else if (PAGE_BITS == 0) begin : g_unit
      assign page_next = ptr;
    end else begin : g_page
      assign page_next = {ptr[AW-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + PAGE_BITS'(1)};

      AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (inc_page && !load) |=> ptr[AW-1:PAGE_BITS] == $past(ptr[AW-1:PAGE_BITS])); // R5
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           ptr <= '0;
    else if (load)     ptr <= load_val;
    else if (inc_page) ptr <= page_next;
    else if (inc_full) ptr <= full_next;
  end

  AST_FULL_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc_full && !load && !inc_page) |=> ptr == AW'($past(ptr) + AW'(1))); // R7
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import i2c_mem_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          wr_protect,
  input  logic          mem_busy,
  input  logic [7:0]    mem_rdata,
  input  logic [AW-1:0] ptr,
  output logic          sda_oe,
  output logic          ptr_load,
  output logic [AW-1:0] ptr_load_val,
  output logic          ptr_inc_page,
  output logic          ptr_inc_full,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic          mem_commit
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  proto_st_t         state;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              rd_dir;
  logic              wrote;
  logic              m_ack;
  logic              dev_done;

  assign dev_done = (state == ST_DEV) && scl_fall && (cnt == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      sh           <= '0;
      cnt          <= '0;
      rd_dir       <= 1'b0;
      wrote        <= 1'b0;
      m_ack        <= 1'b0;
      sda_oe       <= 1'b0;
      ptr_load     <= 1'b0;
      ptr_load_val <= '0;
      ptr_inc_page <= 1'b0;
      ptr_inc_full <= 1'b0;
      mem_we       <= 1'b0;
      mem_waddr    <= '0;
      mem_wdata    <= '0;
      mem_commit   <= 1'b0;
    end else begin
      mem_we       <= 1'b0;
      mem_commit   <= 1'b0;
      ptr_load     <= 1'b0;
      ptr_inc_page <= 1'b0;
      ptr_inc_full <= 1'b0;
      if (mem_busy) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_det) begin
        mem_commit <= wrote;
        wrote      <= 1'b0;
        state      <= ST_IDLE;
        sda_oe     <= 1'b0;
      end else if (start_det) begin
        state  <= ST_DEV;
        cnt    <= '0;
        wrote  <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_DEV, ST_MADDR, ST_WDATA: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == FULL) begin
              if (state == ST_DEV) begin
                if (sh[7:1] == DEV_ADDR && (sh[0] || !wr_protect)) begin
                  rd_dir <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_DEV_ACK;
                end else begin
                  state  <= ST_IDLE;
                end
              end else if (state == ST_MADDR) begin
                ptr_load     <= 1'b1;
                ptr_load_val <= sh[AW-1:0];
                sda_oe       <= 1'b1;
                state        <= ST_MADDR_ACK;
              end else begin
                mem_we       <= 1'b1;
                mem_waddr    <= ptr;
                mem_wdata    <= sh;
                ptr_inc_page <= 1'b1;
                wrote        <= 1'b1;
                sda_oe       <= 1'b1;
                state        <= ST_WDATA_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_dir) begin
                sh           <= mem_rdata;
                sda_oe       <= ~mem_rdata[7];
                ptr_inc_full <= 1'b1;
                state        <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_MADDR;
              end
            end
          end
          ST_MADDR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_RACK;
              end else begin
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~sh[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (m_ack) begin
                sh           <= mem_rdata;
                sda_oe       <= ~mem_rdata[7];
                ptr_inc_full <= 1'b1;
                cnt          <= '0;
                state        <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R4
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_commit |=> !mem_commit); // R6
  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    mem_commit |-> $past(stop_det)); // R6
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(mem_busy) |-> (!sda_oe && !mem_we)); // R10
  AST_WP_NACK: assert property (@(posedge clk) disable iff (rst)
    (dev_done && !sh[0] && wr_protect && !mem_busy && !stop_det && !start_det) |=> !sda_oe); // R11
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int         AW          = 8,
  parameter int         PAGE_BITS   = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull_low,
  input  logic          wr_protect,
  input  logic          mem_busy,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic          mem_commit
);
  logic          scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic          ptr_load, ptr_inc_page, ptr_inc_full;
  logic [AW-1:0] ptr_load_val, ptr;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_addr_ptr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_load_val),
    .inc_page(ptr_inc_page), .inc_full(ptr_inc_full), .ptr(ptr)
  );

  i2c_proto_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
    .wr_protect(wr_protect), .mem_busy(mem_busy), .mem_rdata(mem_rdata),
    .ptr(ptr), .sda_oe(sda_pull_low), .ptr_load(ptr_load),
    .ptr_load_val(ptr_load_val), .ptr_inc_page(ptr_inc_page),
    .ptr_inc_full(ptr_inc_full), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_commit(mem_commit)
  );

  assign mem_raddr = ptr;
endmodule

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;
  localparam int         Q      = 10;
  localparam int         BUSY_N = 400;
  localparam logic [6:0] DEV    = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       scl_m = 1'b1, sda_m_low = 1'b0, wr_protect = 1'b0;
  logic       sda_pull_low, mem_we, mem_commit, mem_busy;
  logic [7:0] mem_raddr, mem_waddr, mem_wdata, mem_rdata;
  logic       sda_line;
  assign sda_line = !(sda_m_low || sda_pull_low);

  i2c_mem_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_low(sda_pull_low), .wr_protect(wr_protect), .mem_busy(mem_busy),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_commit(mem_commit)
  );

  // memory model: staging page buffer, array, busy timer
  logic [7:0] mem [0:255];
  logic [7:0] stage [0:255];
  logic       stage_v [0:255];
  int         busy_cnt = 0, commit_cnt = 0, we_cnt = 0;
  logic       stage_clr = 1'b0;
  assign mem_busy = (busy_cnt != 0);

  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 8'(i) ^ 8'hA5; stage_v[i] = 1'b0; stage[i] = 8'h00;
  end

  always @(posedge clk) begin
    mem_rdata <= mem[mem_raddr];
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (mem_we) begin
      stage[mem_waddr] <= mem_wdata; stage_v[mem_waddr] <= 1'b1; we_cnt <= we_cnt + 1;
    end
    if (mem_commit) begin
      for (int i = 0; i < 256; i++) if (stage_v[i]) begin mem[i] <= stage[i]; stage_v[i] <= 1'b0; end
      busy_cnt <= BUSY_N; commit_cnt <= commit_cnt + 1;
    end
    if (stage_clr) for (int i = 0; i < 256; i++) stage_v[i] <= 1'b0;
  end

  int checks = 0, errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m_low = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m_low = 1'b1; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m_low = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m_low = 1'b0; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m_low = !b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m_low = 1'b0; wq(); scl_m = 1'b1; wq(); ack = !sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    send_byte(b, a);
    chk(req, int'(a), int'(exp_ack));
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
    end
    wq(); sda_m_low = give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m_low = 1'b0;
  endtask

  task automatic wait_ready();
    while (mem_busy) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic set_ptr(input logic [7:0] a, input string req);
    bus_start(); send_chk({DEV, 1'b0}, 1'b1, req); send_chk(a, 1'b1, req);
  endtask

  task automatic t_reset();
    chk("R1 pull-low", int'(sda_pull_low), 0);
    chk("R1 strobe", int'(mem_we), 0);
    chk("R1 commit", int'(mem_commit), 0);
  endtask

  task automatic t_wrong_addr();
    int c0 = commit_cnt, w0 = we_cnt;
    bus_start();
    send_chk({7'h51, 1'b0}, 1'b0, "R2 foreign address nack");
    send_chk(8'h00, 1'b0, "R2 ignored byte nack");
    bus_stop();
    chk("R2 no strobe", we_cnt - w0, 0);
    chk("R2 no commit", commit_cnt - c0, 0);
  endtask

  task automatic t_byte_write_poll();
    int c0 = commit_cnt, w0 = we_cnt;
    set_ptr(8'h20, "R3 address/pointer ack");
    send_chk(8'h3C, 1'b1, "R4 data ack");
    bus_stop();
    chk("R4 one strobe", we_cnt - w0, 1);
    chk("R6 commit on stop", commit_cnt - c0, 1);
    bus_start();
    send_chk({DEV, 1'b0}, 1'b0, "R10 nack while busy");
    bus_stop();
    wait_ready();
    bus_start();
    send_chk({DEV, 1'b0}, 1'b1, "R10 ack after busy");
    bus_stop();
    chk("R6 no commit without data", commit_cnt - c0, 1);
    chk("R4 byte stored", int'(mem[8'h20]), 8'h3C);
    chk("R4 neighbour kept", int'(mem[8'h21]), 8'h21 ^ 8'hA5);
  endtask

  task automatic t_page_wrap();
    set_ptr(8'h06, "R5 setup");
    send_chk(8'h11, 1'b1, "R5"); send_chk(8'h22, 1'b1, "R5");
    send_chk(8'h33, 1'b1, "R5"); send_chk(8'h44, 1'b1, "R5");
    bus_stop(); wait_ready();
    chk("R5 addr 06", int'(mem[8'h06]), 8'h11);
    chk("R5 addr 07", int'(mem[8'h07]), 8'h22);
    chk("R5 wrap to 00", int'(mem[8'h00]), 8'h33);
    chk("R5 wrap to 01", int'(mem[8'h01]), 8'h44);
    chk("R5 next page kept", int'(mem[8'h08]), 8'h08 ^ 8'hA5);
  endtask

  task automatic t_page_overflow();
    set_ptr(8'h10, "R5 setup");
    for (int i = 0; i < 10; i++) send_chk(8'(8'h80 + i), 1'b1, "R5 overflow ack");
    bus_stop(); wait_ready();
    chk("R5 overwrite 10", int'(mem[8'h10]), 8'h88);
    chk("R5 overwrite 11", int'(mem[8'h11]), 8'h89);
    chk("R5 kept 12", int'(mem[8'h12]), 8'h82);
    chk("R5 kept 17", int'(mem[8'h17]), 8'h87);
    chk("R5 page end", int'(mem[8'h18]), 8'h18 ^ 8'hA5);
  endtask

  task automatic t_reads();
    logic [7:0] b;
    set_ptr(8'h20, "R8 random setup");
    bus_start(); send_chk({DEV, 1'b1}, 1'b1, "R3 read address ack");
    recv_byte(1'b0, b); bus_stop();
    chk("R8 random read", int'(b), 8'h3C);
    set_ptr(8'h06, "R7 setup");
    bus_start(); send_chk({DEV, 1'b1}, 1'b1, "R7");
    recv_byte(1'b1, b); chk("R7 seq 06", int'(b), 8'h11);
    recv_byte(1'b1, b); chk("R7 seq 07", int'(b), 8'h22);
    recv_byte(1'b1, b); chk("R7 seq crosses page 08", int'(b), 8'h08 ^ 8'hA5);
    recv_byte(1'b0, b); chk("R7 seq 09", int'(b), 8'h09 ^ 8'hA5);
    repeat (6) @(negedge clk);
    chk("R9 released after nack", int'(sda_pull_low), 0);
    recv_byte(1'b0, b); chk("R9 clocks ignored", int'(b), 8'hFF);
    bus_stop();
    bus_start(); send_chk({DEV, 1'b1}, 1'b1, "R8");
    recv_byte(1'b0, b); bus_stop();
    chk("R8 current address read", int'(b), 8'h0A ^ 8'hA5);
    set_ptr(8'hFF, "R7 setup");
    bus_start(); send_chk({DEV, 1'b1}, 1'b1, "R7");
    recv_byte(1'b1, b); chk("R7 top address", int'(b), 8'hFF ^ 8'hA5);
    recv_byte(1'b0, b); chk("R7 wrap to 00", int'(b), 8'h33);
    bus_stop();
  endtask

  task automatic t_protect();
    logic [7:0] b;
    int w0 = we_cnt;
    wr_protect = 1'b1;
    bus_start(); send_chk({DEV, 1'b0}, 1'b0, "R11 write nack");
    send_chk(8'h20, 1'b0, "R11 ignored"); send_chk(8'h77, 1'b0, "R11 ignored");
    bus_stop();
    bus_start(); send_chk({DEV, 1'b1}, 1'b1, "R11 read ack");
    recv_byte(1'b0, b); bus_stop();
    wr_protect = 1'b0;
    chk("R11 no strobe", we_cnt - w0, 0);
    chk("R11 memory kept", int'(mem[8'h20]), 8'h3C);
  endtask

  task automatic t_rep_start();
    logic [7:0] b;
    int c0 = commit_cnt;
    set_ptr(8'h30, "R6 setup");
    send_chk(8'h99, 1'b1, "R6 data ack");
    bus_start(); send_chk({DEV, 1'b1}, 1'b1, "R6 read after restart");
    recv_byte(1'b0, b); bus_stop();
    chk("R8 pointer after write", int'(b), 8'h31 ^ 8'hA5);
    chk("R6 no commit on restart", commit_cnt - c0, 0);
    @(negedge clk); stage_clr = 1'b1; @(negedge clk); stage_clr = 1'b0;
    chk("R6 byte not stored", int'(mem[8'h30]), 8'h30 ^ 8'hA5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_wrong_addr();
    t_byte_write_poll();
    t_page_wrap();
    t_page_overflow();
    t_reads();
    t_protect();
    t_rep_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule